// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block tracks which power mode a microcontroller core occupies and picks the mode for the next cycle. It reacts to four events: a one-cycle strobe raised when the core executes its sleep instruction, an interrupt strobe, a core reset input, and an active-low hardware standby pin. A sleep request leads to a different mode depending on the current mode and on four control bits. These bits are standby-select, direct-transfer, low-speed-on and timer prescaler-select. Interrupts wake the core from the sleeping modes.

The block covers six modes. High-speed runs everything from the main clock. Sub-active runs the CPU from the subclock with only the timer channels and watchdogs alive. Sub-sleep and watch stop the CPU while the subclock timers keep running. Software standby and hardware standby stop everything. Two direct transitions move between high-speed and sub-active without passing through a standby mode. When the core jumps from sub-active straight up to high-speed, the block emits a one-cycle strobe that tells the clock logic to force its divider field to zero.

The block decodes the mode into these outputs:
- a clock-select line,
- a CPU enable,
- an enable for the general peripherals,
- one enable per timer channel,
- one enable per watchdog unit.

Oscillator settling, register access and the clock gating itself live outside.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode becomes high-speed. The mode encoding is high-speed=0, sub-active=1, sub-sleep=2, watch=3, software standby=4, hardware standby=5. After that edge `div_clr_o` is 0.
- R2: `stby_n` low at a clock edge moves the block to hardware standby from any mode, whatever the other inputs are.
- R3: With `stby_n` high, `core_rst` high moves the block to high-speed from any mode. Hardware standby is left only this way, and it is held while `core_rst` is low.
- R4: A sleep request in high-speed mode with standby-select, direct-transfer, low-speed-on and prescaler-select all 1 moves the block to sub-active.
- R5: A sleep request in high-speed mode with standby-select=1 and direct-transfer=0 moves the block to watch when prescaler-select=1, and to software standby when prescaler-select=0.
- R6: A sleep request in sub-active mode with prescaler-select=1 leads to one of three modes:
  - standby-select=1 and direct-transfer=0: watch.
  - standby-select=0 and low-speed-on=1: sub-sleep.
  - standby-select=1, direct-transfer=1 and low-speed-on=0: high-speed. Only this transition raises `div_clr_o` for exactly one cycle, in the same cycle the new mode appears.
- R7: An interrupt wakes the sleeping modes:
  - In sub-sleep it leads to sub-active.
  - In watch it leads to sub-active when low-speed-on=1, and to high-speed otherwise.
  - In software standby it leads to high-speed.
- R8: Some events leave the mode unchanged:
  - a sleep request whose bit combination matches no rule above;
  - a sleep request in a sleeping mode;
  - an interrupt in high-speed or sub-active mode;
  - a cycle with no event.
- R9: The outputs are decoded from the mode as follows:
  - `clk_sub_o` is 1 in sub-active, sub-sleep and watch, and 0 otherwise.
  - `cpu_en_o` is 1 in high-speed and sub-active only.
  - `per_en_o` is 1 in high-speed only.
  - All bits of `tmr_en_o` and `wdt_en_o` are 1 in high-speed, sub-active, sub-sleep and watch, and 0 in both standby modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sleep_req | input | 1 | Sleep instruction strobe |
| irq | input | 1 | Interrupt strobe |
| core_rst | input | 1 | Core reset request, active high |
| stby_n | input | 1 | Hardware standby pin, active low |
| sel_stby | input | 1 | Standby-select control bit |
| sel_direct | input | 1 | Direct-transfer control bit |
| sel_lowspd | input | 1 | Low-speed-on control bit |
| sel_presc | input | 1 | Timer prescaler-select control bit |
| mode_o | output | 3 | Current mode code |
| clk_sub_o | output | 1 | 1 selects the subclock, 0 the main clock |
| cpu_en_o | output | 1 | CPU run enable |
| per_en_o | output | 1 | General peripheral enable |
| tmr_en_o | output | NUM_TMR | Per-timer-channel enables |
| wdt_en_o | output | NUM_WDT | Per-watchdog enables |
| div_clr_o | output | 1 | One-cycle clear strobe for the clock divider field |

## Verification
The mode register samples the events and control bits at a rising edge, and every result appears right after that same edge. This applies to `mode_o`, to all decoded enables and to `div_clr_o`, which is registered alongside the mode. Nothing is due later than one edge after its stimulus. The bench therefore drives each stimulus on a falling edge and compares all outputs 1 ns after the following rising edge. It compares them against a model state advanced once per step. One extra idle step after the direct upward transition confirms that the clear strobe has dropped again.

// File: rtl/lpm_pkg.sv
// Package: shared mode encoding and control-bit bundle for the power mode
// controller. Assumes 3-bit mode codes; values 6 and 7 are unused.
package lpm_pkg;

    typedef enum logic [2:0] {
        PM_HIGH   = 3'd0,
        PM_SUBACT = 3'd1,
        PM_SUBSLP = 3'd2,
        PM_WATCH  = 3'd3,
        PM_SWSTBY = 3'd4,
        PM_HWSTBY = 3'd5
    } pm_mode_e;

    typedef struct packed {
        logic stby;
        logic direct;
        logic lowspd;
        logic presc;
    } pm_ctl_t;

    typedef struct packed {
        logic sleep;
        logic irq;
        logic rst;
        logic stby_n;
    } pm_evt_t;

endpackage

// File: rtl/lpm_next.sv
// Module: next-mode decision. Purely combinational; picks exactly one next
// mode per cycle. Priority: standby pin low, then core reset, then the
// per-mode sleep/interrupt rules. Assumes event strobes are synchronous.
module lpm_next
    import lpm_pkg::*;
(
    input  pm_mode_e cur,
    input  pm_evt_t  evt,
    input  pm_ctl_t  ctl,
    output pm_mode_e nxt,
    output logic     direct_up
);

    logic hs_to_sub;
    logic hs_to_watch;
    logic hs_to_sw;
    logic sa_to_watch;
    logic sa_to_ssl;
    logic sa_to_hs;

    // Decode the sleep-request bit combinations that define a transition.
    always_comb begin
        hs_to_sub   = ctl.stby & ctl.direct & ctl.lowspd & ctl.presc;
        hs_to_watch = ctl.stby & ~ctl.direct & ctl.presc;
        hs_to_sw    = ctl.stby & ~ctl.direct & ~ctl.presc;
        sa_to_watch = ctl.stby & ~ctl.direct & ctl.presc;
        sa_to_ssl   = ~ctl.stby & ctl.lowspd & ctl.presc;
        sa_to_hs    = ctl.stby & ctl.direct & ~ctl.lowspd & ctl.presc;
    end

    // Choose the next mode with the fixed event priority.
    always_comb begin
        nxt = cur;
        if (!evt.stby_n) begin
            nxt = PM_HWSTBY;
        end else if (evt.rst) begin
            nxt = PM_HIGH;
        end else begin
            unique case (cur)
                PM_HIGH: begin
                    if (evt.sleep) begin
                        if (hs_to_sub)        nxt = PM_SUBACT;
                        else if (hs_to_watch) nxt = PM_WATCH;
                        else if (hs_to_sw)    nxt = PM_SWSTBY;
                    end
                end
                PM_SUBACT: begin
                    if (evt.sleep) begin
                        if (sa_to_watch)    nxt = PM_WATCH;
                        else if (sa_to_ssl) nxt = PM_SUBSLP;
                        else if (sa_to_hs)  nxt = PM_HIGH;
                    end
                end
                PM_SUBSLP: begin
                    if (evt.irq) nxt = PM_SUBACT;
                end
                PM_WATCH: begin
                    if (evt.irq) nxt = ctl.lowspd ? PM_SUBACT : PM_HIGH;
                end
                PM_SWSTBY: begin
                    if (evt.irq) nxt = PM_HIGH;
                end
                PM_HWSTBY: begin
                    nxt = PM_HWSTBY;
                end
                default: begin
                    nxt = PM_HIGH;
                end
            endcase
        end
    end

    // Flag the direct upward transfer that must clear the clock divider.
    always_comb begin
        direct_up = evt.stby_n & ~evt.rst & evt.sleep
                  & (cur == PM_SUBACT) & sa_to_hs;
    end

endmodule

// File: rtl/lpm_state.sv
// Module: mode register and divider-clear strobe register.
// Synchronous active-low reset to high-speed; assumes one clock domain.
module lpm_state
    import lpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pm_mode_e nxt,
    input  logic     direct_up,
    output pm_mode_e cur,
    output logic     div_clr
);

    // Hold the current mode and the one-cycle clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= PM_HIGH;
            div_clr <= 1'b0;
        end else begin
            cur     <= nxt;
            div_clr <= direct_up;
        end
    end

endmodule

// File: rtl/lpm_outdec.sv
// Module: decodes the mode into clock-select and enable lines.
// One enable bit per timer channel and per watchdog, built with generate.
// Assumes a legal mode code; illegal codes decode to everything off.
module lpm_outdec
    import lpm_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int NUM_WDT = 2
) (
    input  pm_mode_e           cur,
    output logic               clk_sub,
    output logic               cpu_en,
    output logic               per_en,
    output logic [NUM_TMR-1:0] tmr_en,
    output logic [NUM_WDT-1:0] wdt_en
);

    logic timers_on;

    // Map each mode to its clock source and enable pattern.
    always_comb begin
        clk_sub   = 1'b0;
        cpu_en    = 1'b0;
        per_en    = 1'b0;
        timers_on = 1'b0;
        unique case (cur)
            PM_HIGH: begin
                cpu_en    = 1'b1;
                per_en    = 1'b1;
                timers_on = 1'b1;
            end
            PM_SUBACT: begin
                clk_sub   = 1'b1;
                cpu_en    = 1'b1;
                timers_on = 1'b1;
            end
            PM_SUBSLP, PM_WATCH: begin
                clk_sub   = 1'b1;
                timers_on = 1'b1;
            end
            default: begin
                timers_on = 1'b0;
            end
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
            // Drive one timer channel enable.
            assign tmr_en[gi] = timers_on;
        end
        for (gi = 0; gi < NUM_WDT; gi++) begin : g_wdt
            // Drive one watchdog unit enable.
            assign wdt_en[gi] = timers_on;
        end
    endgenerate

endmodule

// File: rtl/lpm_ctrl.sv
// Module: top of the low-power mode transition controller. Bundles the
// inputs, runs the next-mode decision, the mode register and the output
// decoder. Assumes all inputs are synchronous to clk.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int NUM_WDT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               irq,
    input  logic               core_rst,
    input  logic               stby_n,
    input  logic               sel_stby,
    input  logic               sel_direct,
    input  logic               sel_lowspd,
    input  logic               sel_presc,
    output logic [2:0]         mode_o,
    output logic               clk_sub_o,
    output logic               cpu_en_o,
    output logic               per_en_o,
    output logic [NUM_TMR-1:0] tmr_en_o,
    output logic [NUM_WDT-1:0] wdt_en_o,
    output logic               div_clr_o
);

    pm_evt_t  evt;
    pm_ctl_t  ctl;
    pm_mode_e cur;
    pm_mode_e nxt;
    logic     direct_up;

    // Gather the event and control inputs into bundles.
    always_comb begin
        evt = '{sleep: sleep_req, irq: irq, rst: core_rst, stby_n: stby_n};
        ctl = '{stby: sel_stby, direct: sel_direct, lowspd: sel_lowspd,
                presc: sel_presc};
    end

    lpm_next u_next (
        .cur       (cur),
        .evt       (evt),
        .ctl       (ctl),
        .nxt       (nxt),
        .direct_up (direct_up)
    );

    lpm_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt       (nxt),
        .direct_up (direct_up),
        .cur       (cur),
        .div_clr   (div_clr_o)
    );

    lpm_outdec #(
        .NUM_TMR (NUM_TMR),
        .NUM_WDT (NUM_WDT)
    ) u_dec (
        .cur     (cur),
        .clk_sub (clk_sub_o),
        .cpu_en  (cpu_en_o),
        .per_en  (per_en_o),
        .tmr_en  (tmr_en_o),
        .wdt_en  (wdt_en_o)
    );

    assign mode_o = cur;

endmodule

// File: rtl/lpm_ctrl_chk.sv
// Module: assertion checker for lpm_ctrl, attached with bind.
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       irq,
    input logic       core_rst,
    input logic       stby_n,
    input logic       sel_stby,
    input logic       sel_direct,
    input logic       sel_lowspd,
    input logic       sel_presc,
    input logic [2:0] mode_o,
    input logic       clk_sub_o,
    input logic       cpu_en_o,
    input logic       per_en_o,
    input logic       div_clr_o
);

    a_r2_pin_forces_hw: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_n |=> mode_o == 3'd5);

    a_r3_reset_to_high: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n && core_rst) |=> mode_o == 3'd0);

    a_r3_hw_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5 && !core_rst) |=> mode_o == 3'd5);

    a_r4_high_to_subact: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && stby_n && !core_rst && sleep_req && sel_stby
         && sel_direct && sel_lowspd && sel_presc) |=> mode_o == 3'd1);

    a_r6_subact_to_watch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && stby_n && !core_rst && sleep_req && sel_stby
         && !sel_direct && sel_presc) |=> mode_o == 3'd3);

    a_r6_divclr_only_direct: assert property (@(posedge clk) disable iff (!rst_n)
        div_clr_o |-> (mode_o == 3'd0 && $past(mode_o) == 3'd1));

    a_r7_subsleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && stby_n && !core_rst && irq) |=> mode_o == 3'd1);

    a_r9_subclock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 || mode_o == 3'd2 || mode_o == 3'd3) |-> clk_sub_o);

    a_r9_sleep_stops_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o >= 3'd2) |-> (!cpu_en_o && !per_en_o));

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .irq        (irq),
    .core_rst   (core_rst),
    .stby_n     (stby_n),
    .sel_stby   (sel_stby),
    .sel_direct (sel_direct),
    .sel_lowspd (sel_lowspd),
    .sel_presc  (sel_presc),
    .mode_o     (mode_o),
    .clk_sub_o  (clk_sub_o),
    .cpu_en_o   (cpu_en_o),
    .per_en_o   (per_en_o),
    .div_clr_o  (div_clr_o)
);

// File: tb/tb_lpm_ctrl.sv
// Bench: directed corner cases plus seeded random stimulus, checked
// against a bench-side model of the mode rules.
module tb_lpm_ctrl;

    localparam int NT = 4;
    localparam int NW = 2;

    logic clk = 1'b0;
    logic rst_n, sleep_req, irq, core_rst, stby_n;
    logic sel_stby, sel_direct, sel_lowspd, sel_presc;
    logic [2:0] mode_o;
    logic clk_sub_o, cpu_en_o, per_en_o, div_clr_o;
    logic [NT-1:0] tmr_en_o;
    logic [NW-1:0] wdt_en_o;

    int total = 0;
    int bad = 0;
    logic [2:0] exp_mode;

    always #4 clk = ~clk;

    lpm_ctrl #(.NUM_TMR(NT), .NUM_WDT(NW)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq(irq),
        .core_rst(core_rst), .stby_n(stby_n), .sel_stby(sel_stby),
        .sel_direct(sel_direct), .sel_lowspd(sel_lowspd),
        .sel_presc(sel_presc), .mode_o(mode_o), .clk_sub_o(clk_sub_o),
        .cpu_en_o(cpu_en_o), .per_en_o(per_en_o), .tmr_en_o(tmr_en_o),
        .wdt_en_o(wdt_en_o), .div_clr_o(div_clr_o)
    );

    function automatic logic [2:0] f_next(input logic [2:0] m,
            input logic sl, input logic iq, input logic rs, input logic sn,
            input logic s, input logic d, input logic l, input logic p);
        if (!sn) return 3'd5;
        if (rs) return 3'd0;
        case (m)
            3'd0: if (sl) begin
                if (s && d && l && p) return 3'd1;
                if (s && !d && p) return 3'd3;
                if (s && !d && !p) return 3'd4;
            end
            3'd1: if (sl) begin
                if (s && !d && p) return 3'd3;
                if (!s && l && p) return 3'd2;
                if (s && d && !l && p) return 3'd0;
            end
            3'd2: if (iq) return 3'd1;
            3'd3: if (iq) return l ? 3'd1 : 3'd0;
            3'd4: if (iq) return 3'd0;
            default: ;
        endcase
        return m;
    endfunction

    function automatic string f_tag(input logic [2:0] m, input logic [2:0] n,
            input logic sl, input logic iq, input logic rs, input logic sn);
        if (!sn) return "R2";
        if (rs || m == 3'd5) return "R3";
        if (m == 3'd0 && sl && n == 3'd1) return "R4";
        if (m == 3'd0 && sl && n != m) return "R5";
        if (m == 3'd1 && sl && n != m) return "R6";
        if (m >= 3'd2 && iq && n != m) return "R7";
        return "R8";
    endfunction

    // expected {clk_sub, cpu, per, timers}
    function automatic logic [3:0] f_out(input logic [2:0] m);
        case (m)
            3'd0: return 4'b0111;
            3'd1: return 4'b1101;
            3'd2, 3'd3: return 4'b1001;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic chk_outs(input logic [2:0] m);
        logic [3:0] o;
        o = f_out(m);
        chk("R9", {28'd0, clk_sub_o, cpu_en_o, per_en_o,
                   (&tmr_en_o) & (&wdt_en_o)}, {28'd0, o}, "decode");
        chk("R9", {31'd0, (|tmr_en_o) ^ (&tmr_en_o)}, 32'd0, "tmr uniform");
        chk("R9", {31'd0, (|wdt_en_o) ^ (&wdt_en_o)}, 32'd0, "wdt uniform");
    endtask

    task automatic step(input logic sl, input logic iq, input logic rs,
                        input logic sn, input logic [3:0] bits);
        logic [2:0] n;
        logic dx;
        string t;
        @(negedge clk);
        sleep_req = sl; irq = iq; core_rst = rs; stby_n = sn;
        {sel_stby, sel_direct, sel_lowspd, sel_presc} = bits;
        n  = f_next(exp_mode, sl, iq, rs, sn, bits[3], bits[2], bits[1], bits[0]);
        t  = f_tag(exp_mode, n, sl, iq, rs, sn);
        dx = sn && !rs && sl && exp_mode == 3'd1 && bits == 4'b1101;
        @(posedge clk);
        #1;
        exp_mode = n;
        chk(t, {29'd0, mode_o}, {29'd0, n}, "mode");
        chk("R6", {31'd0, div_clr_o}, {31'd0, dx}, "div_clr");
        chk_outs(n);
    endtask

    task automatic expect_mode(input logic [2:0] m, input string tag);
        chk(tag, {29'd0, mode_o}, {29'd0, m}, "directed mode");
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; sleep_req = 1'b1; irq = 1'b1; core_rst = 1'b0;
        stby_n = 1'b1; {sel_stby, sel_direct, sel_lowspd, sel_presc} = 4'hF;
        exp_mode = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {29'd0, mode_o}, 32'd0, "reset mode");
        chk("R1", {31'd0, div_clr_o}, 32'd0, "reset div_clr");
        chk_outs(3'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        step(1, 0, 0, 1, 4'b1111); expect_mode(3'd1, "R4");
        step(1, 0, 0, 1, 4'b0011); expect_mode(3'd2, "R6");
        step(1, 0, 0, 1, 4'b1111); expect_mode(3'd2, "R8");
        step(0, 1, 0, 1, 4'b0000); expect_mode(3'd1, "R7");
        step(0, 1, 0, 1, 4'b0000); expect_mode(3'd1, "R8");
        step(1, 0, 0, 1, 4'b0001); expect_mode(3'd1, "R8");
        step(1, 0, 0, 1, 4'b1101); expect_mode(3'd0, "R6");
        chk("R6", {31'd0, div_clr_o}, 32'd1, "direct strobe");
        step(0, 0, 0, 1, 4'b0000);
        chk("R6", {31'd0, div_clr_o}, 32'd0, "strobe one cycle");
        step(1, 0, 0, 1, 4'b1011); expect_mode(3'd3, "R5");
        step(0, 1, 0, 1, 4'b0000); expect_mode(3'd0, "R7");
        step(1, 0, 0, 1, 4'b1000); expect_mode(3'd4, "R5");
        step(0, 1, 0, 1, 4'b0000); expect_mode(3'd0, "R7");
        step(1, 0, 0, 1, 4'b0111); expect_mode(3'd0, "R8");
        step(1, 0, 0, 1, 4'b1111);
        step(1, 0, 0, 1, 4'b1001); expect_mode(3'd3, "R6");
        step(0, 1, 0, 1, 4'b0010); expect_mode(3'd1, "R7");
        step(1, 0, 1, 1, 4'b1101); expect_mode(3'd0, "R3");
        chk("R6", {31'd0, div_clr_o}, 32'd0, "no strobe on reset");
        step(1, 1, 1, 0, 4'b1111); expect_mode(3'd5, "R2");
        step(0, 1, 0, 1, 4'b1111); expect_mode(3'd5, "R3");
        step(1, 0, 0, 1, 4'b1111); expect_mode(3'd5, "R3");
        step(0, 0, 1, 1, 4'b0000); expect_mode(3'd0, "R3");

        // Seeded random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] b;
            b = 4'($urandom);
            step(($urandom % 3) == 0, ($urandom % 3) == 0,
                 ($urandom % 40) == 0, ($urandom % 50) != 0, b);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule